// File: doc/BRIEF.md
# Cascadable Binary Search Memory with Priority Flags

This block is a small binary content-addressable memory. It holds a set of data words, each with its own validity bit. A write stores a word and marks the entry either occupied or empty. A read reports the occupancy of one entry. A compare searches every occupied entry in parallel for a key, and reports the lowest matching entry index on a result bus, next to a page number taken from a local configuration register.

Several identical instances can be stacked to build a deeper table. A match chain runs through the stack: each instance passes an active-low match flag down to the next lower-priority instance. An instance that sees a match from above keeps its result bus disabled, so only the highest-priority matching instance drives the shared result. A second active-low chain reports that the whole stack is full. Operations are synchronous to one clock. Results register on the clock edge that ends the operation.

Top module: `cam_cascade`

## Requirements
- R1: After reset every entry is empty, `mf_n` is 1, `ff_n` is 1, `vld_n_out` is 1, `res_addr` is 0 and `res_page` is 0.
- R2: `op_kind` 2'b10 is a read. One cycle after it, `vld_n_out` shows 0 if entry `op_addr` is occupied and 1 if it is empty, and `res_addr` shows `op_addr`.
- R3: `op_kind` 2'b01 is a write. It stores `op_data` in entry `op_addr`, marks the entry occupied when `vld_n_in` is 0 and empty when `vld_n_in` is 1. An empty entry never matches a compare.
- R4: `op_kind` 2'b11 is a compare of `op_data`. One cycle later `mf_n` is 0 if an occupied entry holds the key or `mi_n` was 0 during the compare, and 1 otherwise.
- R5: One cycle after a compare, `res_addr` is the lowest index of the matching occupied entries, or 0 if none matched.
- R6: `mf_n` changes only on a compare. It keeps the latest compare result through reads, writes and idle cycles, even while `res_addr` shows a read address.
- R7: `ff_n` is 0 exactly when every entry is occupied and `fi_n` is 0. Otherwise it is 1.
- R8: `res_en` is 1 only when `res_oe_n` is 0 and `mi_n` is 1. A low `mi_n` overrides the enable.
- R9: With `page_wr` high, `page_in` loads the page register. From the next cycle it appears on `res_page`.
- R10: `op_kind` 2'b00 is idle. It leaves the stored entries, `res_addr`, `vld_n_out` and `mf_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| op_kind | input | 2 | Operation: 00 idle, 01 write, 10 read, 11 compare |
| op_addr | input | 4 | Entry index for write and read |
| op_data | input | 32 | Write data or compare key |
| vld_n_in | input | 1 | Write validity: 0 occupied, 1 empty |
| page_wr | input | 1 | Load strobe for the page register |
| page_in | input | 4 | New page register value |
| res_oe_n | input | 1 | Active-low result bus enable request |
| mi_n | input | 1 | Active-low match from the higher-priority device |
| fi_n | input | 1 | Active-low full from the neighbouring device |
| mf_n | output | 1 | Active-low match flag to the lower-priority device |
| ff_n | output | 1 | Active-low full flag |
| vld_n_out | output | 1 | Validity of the last read entry, 0 occupied |
| res_en | output | 1 | Result bus drive enable |
| res_page | output | 4 | Page register value on the result bus |
| res_addr | output | 4 | Match or access address on the result bus |

## Verification
A corrupted validity bit shows up on `ff_n` in the same cycle. It also shows up on `vld_n_out` one cycle after a read of that entry, and as a false or missing match one cycle after any compare with that entry's key. A wrong encoder order or a stale match flag is visible on `res_addr` and `mf_n` one cycle after the compare. The bench keeps these visible by drawing keys from a small pool so that matches, duplicates and empty entries recur. It compares all outputs against its own model on every cycle.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_CMP   = 2'b11
  } cam_op_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         wr_occ,
  output logic [DEPTH-1:0][WIDTH-1:0]  data_q,
  output logic [DEPTH-1:0]             occ_q
);
  logic [DEPTH-1:0] occ_d;

  always_comb begin
    occ_d = occ_q;
    if (wr_en) occ_d[wr_addr] = wr_occ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

  // payload words carry no reset; the occupancy bits gate them
  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [WIDTH-1:0]             key,
  input  logic [DEPTH-1:0][WIDTH-1:0]  data_q,
  input  logic [DEPTH-1:0]             occ_q,
  output logic                         hit,
  output logic [AW-1:0]                hit_idx
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = occ_q[g] && (data_q[g] == key);
  end

  // scan downward so the lowest set index is the last assignment
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = AW'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/cam_result.sv
module cam_result #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_rd,
  input  logic          is_cmp,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_occ,
  input  logic          hit,
  input  logic [AW-1:0] hit_idx,
  input  logic          mi_n,
  output logic          mf_n,
  output logic [AW-1:0] res_addr,
  output logic          vld_n_out
);
  logic          mf_d;
  logic [AW-1:0] addr_d;
  logic          vld_d;

  always_comb begin
    mf_d   = mf_n;
    addr_d = res_addr;
    vld_d  = vld_n_out;
    if (is_cmp) begin
      mf_d   = !(hit || !mi_n);
      addr_d = hit ? hit_idx : '0;
    end
    if (is_rd) begin
      addr_d = rd_addr;
      vld_d  = !rd_occ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_n      <= 1'b1;
      res_addr  <= '0;
      vld_n_out <= 1'b1;
    end else begin
      mf_n      <= mf_d;
      res_addr  <= addr_d;
      vld_n_out <= vld_d;
    end
  end
endmodule

// File: rtl/cam_cascade.sv
module cam_cascade #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int PAGE_W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_kind,
  input  logic [AW-1:0]     op_addr,
  input  logic [WIDTH-1:0]  op_data,
  input  logic              vld_n_in,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              res_oe_n,
  input  logic              mi_n,
  input  logic              fi_n,
  output logic              mf_n,
  output logic              ff_n,
  output logic              vld_n_out,
  output logic              res_en,
  output logic [PAGE_W-1:0] res_page,
  output logic [AW-1:0]     res_addr
);
  import cam_pkg::*;

  cam_op_e                     op;
  logic [1:0]                  rst_sync;
  logic                        rst_q;
  logic [DEPTH-1:0][WIDTH-1:0] data_q;
  logic [DEPTH-1:0]            occ_q;
  logic                        hit;
  logic [AW-1:0]               hit_idx;
  logic [PAGE_W-1:0]           page_d;

  assign op = cam_op_e'(op_kind);

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (op == OP_WRITE),
    .wr_addr (op_addr),
    .wr_data (op_data),
    .wr_occ  (!vld_n_in),
    .data_q  (data_q),
    .occ_q   (occ_q)
  );

  cam_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
    .key     (op_data),
    .data_q  (data_q),
    .occ_q   (occ_q),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  cam_result #(.DEPTH(DEPTH)) u_result (
    .clk       (clk),
    .rst_n     (rst_q),
    .is_rd     (op == OP_READ),
    .is_cmp    (op == OP_CMP),
    .rd_addr   (op_addr),
    .rd_occ    (occ_q[op_addr]),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .mi_n      (mi_n),
    .mf_n      (mf_n),
    .res_addr  (res_addr),
    .vld_n_out (vld_n_out)
  );

  always_comb begin
    page_d = res_page;
    if (page_wr) page_d = page_in;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) res_page <= '0;
    else        res_page <= page_d;
  end

  assign ff_n   = !((&occ_q) && !fi_n);
  assign res_en = !res_oe_n && mi_n;
endmodule

// File: rtl/cam_cascade_chk.sv
module cam_cascade_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_q,
  input logic [1:0]    op_kind,
  input logic          mi_n,
  input logic          fi_n,
  input logic          mf_n,
  input logic          ff_n,
  input logic          res_en,
  input logic [AW-1:0] res_addr,
  input logic          vld_n_out
);
  assert_mf_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_kind != 2'b11) |=> $stable(mf_n));

  assert_mi_forces_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (op_kind == 2'b11 && !mi_n) |=> !mf_n);

  assert_bus_yield_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !mi_n |-> !res_en);

  assert_full_chain_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !ff_n |-> !fi_n);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (op_kind == 2'b00) |=> ($stable(res_addr) && $stable(vld_n_out)));
endmodule

bind cam_cascade cam_cascade_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .op_kind   (op_kind),
  .mi_n      (mi_n),
  .fi_n      (fi_n),
  .mf_n      (mf_n),
  .ff_n      (ff_n),
  .res_en    (res_en),
  .res_addr  (res_addr),
  .vld_n_out (vld_n_out)
);

// File: tb/cam_cascade_test.sv
module cam_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_kind;
  logic [3:0]  op_addr;
  logic [31:0] op_data;
  logic        vld_n_in, page_wr, res_oe_n, mi_n, fi_n;
  logic [3:0]  page_in;
  logic        mf_n, ff_n, vld_n_out, res_en;
  logic [3:0]  res_page, res_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_data [16];
  logic [15:0] m_occ;
  logic        e_mf, e_vld;
  logic [3:0]  e_addr, e_page;

  always #2 clk = ~clk;

  cam_cascade uut (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .vld_n_in(vld_n_in), .page_wr(page_wr),
    .page_in(page_in), .res_oe_n(res_oe_n), .mi_n(mi_n), .fi_n(fi_n),
    .mf_n(mf_n), .ff_n(ff_n), .vld_n_out(vld_n_out), .res_en(res_en),
    .res_page(res_page), .res_addr(res_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest_hit(input logic [31:0] key);
    for (int i = 0; i < 16; i++)
      if (m_occ[i] && m_data[i] == key) return i;
    return -1;
  endfunction

  task automatic check_all();
    chk("R4/R6 mf_n", {31'd0, mf_n}, {31'd0, e_mf});
    chk("R5/R2 res_addr", {28'd0, res_addr}, {28'd0, e_addr});
    chk("R2 vld_n_out", {31'd0, vld_n_out}, {31'd0, e_vld});
    chk("R7 ff_n", {31'd0, ff_n}, {31'd0, !((&m_occ) && !fi_n)});
    chk("R8 res_en", {31'd0, res_en}, {31'd0, !res_oe_n && mi_n});
    chk("R9 res_page", {28'd0, res_page}, {28'd0, e_page});
  endtask

  // drive at a falling edge, let one rising edge act, check at the next falling edge
  task automatic step(input logic [1:0] k, input logic [3:0] a, input logic [31:0] d,
                      input logic vin, input logic mi);
    int lh;
    op_kind = k; op_addr = a; op_data = d; vld_n_in = vin; mi_n = mi;
    @(posedge clk);
    lh = lowest_hit(d);
    case (k)
      2'b01: begin m_data[a] = d; m_occ[a] = !vin; end
      2'b10: begin e_addr = a; e_vld = !m_occ[a]; end
      2'b11: begin e_mf = !(lh >= 0 || !mi); e_addr = (lh >= 0) ? 4'(lh) : 4'd0; end
      default: ;
    endcase
    if (page_wr) e_page = page_in;
    @(negedge clk);
    page_wr = 1'b0;
    check_all();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; op_kind = 2'b00; op_addr = '0; op_data = '0; vld_n_in = 1'b1;
    page_wr = 1'b0; page_in = '0; res_oe_n = 1'b1; mi_n = 1'b1; fi_n = 1'b1;
    m_occ = '0; e_mf = 1'b1; e_vld = 1'b1; e_addr = '0; e_page = '0;
    for (int i = 0; i < 16; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 mf_n", {31'd0, mf_n}, 32'd1);
    chk("R1 ff_n", {31'd0, ff_n}, 32'd1);
    chk("R1 vld_n_out", {31'd0, vld_n_out}, 32'd1);
    chk("R1 res_addr", {28'd0, res_addr}, 32'd0);
    chk("R1 res_page", {28'd0, res_page}, 32'd0);

    // R3 compare on an empty table misses
    step(2'b11, 4'd0, 32'd0, 1'b1, 1'b1);
    chk("R3 empty no match", {31'd0, mf_n}, 32'd1);

    // R7 fill all entries with fi_n low
    fi_n = 1'b0;
    for (int i = 0; i < 16; i++) step(2'b01, 4'(i), 32'(i * 3 + 5), 1'b0, 1'b1);
    chk("R7 full low", {31'd0, ff_n}, 32'd0);
    fi_n = 1'b1; #1;
    chk("R7 fi_n high keeps full high", {31'd0, ff_n}, 32'd1);

    // R5 duplicates: lowest index wins
    step(2'b01, 4'd9, 32'hAAAA, 1'b0, 1'b1);
    step(2'b01, 4'd5, 32'hAAAA, 1'b0, 1'b1);
    step(2'b11, 4'd0, 32'hAAAA, 1'b1, 1'b1);
    chk("R5 lowest index", {28'd0, res_addr}, 32'd5);
    // R3 emptied entry drops out of the search
    step(2'b01, 4'd5, 32'hAAAA, 1'b1, 1'b1);
    step(2'b11, 4'd0, 32'hAAAA, 1'b1, 1'b1);
    chk("R3 empty skipped", {28'd0, res_addr}, 32'd9);
    // R2 and R6 read keeps the match flag
    step(2'b10, 4'd5, 32'd0, 1'b1, 1'b1);
    chk("R2 read empty", {31'd0, vld_n_out}, 32'd1);
    step(2'b10, 4'd2, 32'd0, 1'b1, 1'b1);
    chk("R2 read occupied", {31'd0, vld_n_out}, 32'd0);
    chk("R6 mf_n held after read", {31'd0, mf_n}, 32'd0);
    // R4 a match from above forces the flag; R8 bus yields
    step(2'b11, 4'd0, 32'hDEAD, 1'b1, 1'b1);
    chk("R4 miss", {31'd0, mf_n}, 32'd1);
    res_oe_n = 1'b0;
    step(2'b11, 4'd0, 32'hDEAD, 1'b1, 1'b0);
    chk("R4 mi_n forces match", {31'd0, mf_n}, 32'd0);
    chk("R8 bus off under mi_n", {31'd0, res_en}, 32'd0);
    // R10 idle leaves everything
    step(2'b00, 4'd7, 32'h0000_0005, 1'b1, 1'b1);
    chk("R10 idle addr", {28'd0, res_addr}, 32'd0);
    step(2'b10, 4'd0, 32'd0, 1'b1, 1'b1);
    chk("R10 idle kept entry 0", {31'd0, vld_n_out}, 32'd0);
    // R9 page register
    page_in = 4'hB; page_wr = 1'b1;
    step(2'b00, 4'd0, 32'd0, 1'b1, 1'b1);
    chk("R9 page loaded", {28'd0, res_page}, 32'hB);

    // random phase, keys from a small pool
    for (int n = 0; n < 2000; n++) begin
      logic [1:0] k;
      k        = 2'($urandom_range(0, 3));
      fi_n     = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      res_oe_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin page_wr = 1'b1; page_in = 4'($urandom_range(0, 15)); end
      step(k, 4'($urandom_range(0, 15)), 32'($urandom_range(0, 7)),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule